// File: doc/BRIEF.md
# Status Bit and Mode Command Responder

This block sits on the subsystem side of a dual-redundant serial-bus remote terminal core. It handles the signalling for status bits and mode commands. When the core signals that a command is active, the block latches the subaddress of that command. It then raises the busy status line if the host has marked that subaddress as busy. The decision is made within one clock edge, so busy is settled well before the core samples it.

The block also services three mode commands, each with its own signalling:
- **Synchronize.** The block raises a one-cycle synchronize event. For the data-carrying variant it first assembles the two strobed bytes from the highway, high byte first.
- **Vector word request.** The block drives a host-preloaded vector word onto the highway one byte at a time, while the request line is low.
- **Reset.** A low pulse on the reset-command line produces a timed local reset. This reset clears the synchronize capture logic.

Synchronize and vector transfers do not depend on the busy state.

Top module: `stat_mode_resp`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy`, `sync_evt`, `sync_wd` and `sync_data` are 0 and `sub_rst_n` is 1, as long as no stimulus arrives.
- R2: On the first clock edge at which `cmd_act_n` is sampled low after being high, `subaddr` is latched. `busy` becomes bit `subaddr` of the busy mask after that edge and follows the latched subaddress for as long as `cmd_act_n` stays low. Later changes of `subaddr` are ignored.
- R3: `busy` is 0 after any edge at which `cmd_act_n` is sampled high, and it stays 0 during a command whose latched subaddress has a clear mask bit.
- R4: A falling edge of `sync_n` sampled with `wc4` = 0 gives a one-cycle `sync_evt` with `sync_wd` = 0 after that edge. `sync_data` keeps its previous value.
- R5: While `sync_n` is low, a rising edge of `byte_stb` stores `hw_in` as the high byte when `byte_hi` = 1. With `byte_hi` = 0 it stores `hw_in` as the low byte, loads `sync_data` = {high, low} and gives a one-cycle `sync_evt` with `sync_wd` = 1 after that edge.
- R6: Strobe edges sampled while `sync_n` is high leave `sync_data` unchanged and give no `sync_evt`.
- R7: `hw_oe` equals the inverse of `vec_en_n`. While `vec_en_n` is low, `hw_out` is bits 15:8 of the vector register when `byte_hi` = 1 and bits 7:0 when `byte_hi` = 0. Otherwise `hw_out` is 0.
- R8: Synchronize capture and vector drive behave the same whether `busy` is 1 or 0.
- R9: A falling edge of `rst_cmd_n` sampled at a clock edge drives `sub_rst_n` low for exactly `RST_CYC` (default 4) cycles, starting after that edge.
- R10: While `sub_rst_n` is low, each edge clears the stored high byte, `sync_data`, `sync_evt` and `sync_wd` to 0, and strobes are ignored.
- R11: `mask_we` loads `mask_wdata` into the busy mask, and `vec_we` loads `vec_wdata` into the vector register. The new value is used from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subsystem clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mask_we | input | 1 | Write enable for the busy mask |
| mask_wdata | input | 32 | Busy mask value, one bit per subaddress |
| vec_we | input | 1 | Write enable for the vector register |
| vec_wdata | input | 16 | Vector word value |
| cmd_act_n | input | 1 | Command active from the core, active low |
| subaddr | input | 5 | Subaddress of the current command |
| wc4 | input | 1 | Word count bit 4: 1 = synchronize carries a data word |
| sync_n | input | 1 | Synchronize mode line, active low |
| vec_en_n | input | 1 | Vector word request, active low |
| rst_cmd_n | input | 1 | Reset mode command pulse, active low |
| byte_stb | input | 1 | Byte strobe from the core |
| byte_hi | input | 1 | Byte select: 1 = high byte |
| hw_in | input | 8 | Highway byte from the core |
| busy | output | 1 | Busy status to the core |
| hw_out | output | 8 | Vector byte driven toward the highway |
| hw_oe | output | 1 | Highway drive enable |
| sync_evt | output | 1 | One-cycle synchronize event |
| sync_wd | output | 1 | Event carried a data word |
| sync_data | output | 16 | Last synchronize data word |
| sub_rst_n | output | 1 | Local subsystem reset, active low |

## Verification
Commands are issued to a masked subaddress, to an unmasked subaddress and to subaddress 31. In one case the subaddress input changes mid-command, which separates a latched select from a live one. Synchronize runs both with and without a data word, then with strobes while the sync line is high, and again with strobes during a local reset. This tells capture apart from the ignore paths and the clear path. Vector drive and synchronize capture run while busy is set and again after the vector register and mask are rewritten. This shows that stored values are used and that busy has no effect on either.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned SA_W_DEF   = 5;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned RST_CYC_DEF = 4;
endpackage

// File: rtl/sr_host_regs.sv
module sr_host_regs #(
  parameter int unsigned NSA    = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              mask_we,
  input  logic [NSA-1:0]    mask_wdata,
  input  logic              vec_we,
  input  logic [WORD_W-1:0] vec_wdata,
  output logic [NSA-1:0]    mask_q,
  output logic [WORD_W-1:0] vec_q
);
  logic [NSA-1:0]    mask_d;
  logic [WORD_W-1:0] vec_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    vec_d  = vec_we  ? vec_wdata  : vec_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mask_q <= '0;
      vec_q  <= '0;
    end else begin
      mask_q <= mask_d;
      vec_q  <= vec_d;
    end
  end

  p_mask_load_r11: assert property (@(posedge clk) disable iff (!arst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));
endmodule

// File: rtl/sr_busy_sel.sv
module sr_busy_sel #(
  parameter int unsigned SA_W = 5,
  localparam int unsigned NSA = 1 << SA_W
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            cmd_act_n,
  input  logic [SA_W-1:0] subaddr,
  input  logic [NSA-1:0]  mask,
  output logic            busy
);
  logic            cmd_q, start;
  logic [SA_W-1:0] sa_q, sa_d;
  logic            busy_d;

  always_comb begin
    start  = ~cmd_act_n & cmd_q;
    sa_d   = start ? subaddr : sa_q;
    busy_d = ~cmd_act_n & mask[sa_d];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cmd_q <= 1'b1;
      sa_q  <= '0;
      busy  <= 1'b0;
    end else begin
      cmd_q <= cmd_act_n;
      sa_q  <= sa_d;
      busy  <= busy_d;
    end
  end

  p_busy_idle_r3: assert property (@(posedge clk) disable iff (!arst_n)
    cmd_act_n |=> !busy);
  p_sa_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!cmd_act_n && !cmd_q) |=> (sa_q == $past(sa_q)));
endmodule

// File: rtl/sr_sync_cap.sv
module sr_sync_cap #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              lrst,
  input  logic              sync_n,
  input  logic              wc4,
  input  logic              byte_stb,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] hw_in,
  output logic              sync_evt,
  output logic              sync_wd,
  output logic [WORD_W-1:0] sync_data
);
  logic              sync_q, stb_q, stb_rise, sync_fall;
  logic [BYTE_W-1:0] hi_q, hi_d;
  logic [WORD_W-1:0] data_d;
  logic              evt_d, wd_d;

  always_comb begin
    stb_rise  = byte_stb & ~stb_q;
    sync_fall = ~sync_n & sync_q;
    hi_d   = hi_q;
    data_d = sync_data;
    evt_d  = 1'b0;
    wd_d   = sync_wd;
    if (lrst) begin
      hi_d = '0; data_d = '0; wd_d = 1'b0;
    end else begin
      if (sync_fall && !wc4) begin
        evt_d = 1'b1; wd_d = 1'b0;
      end
      if (stb_rise && !sync_n) begin
        if (byte_hi) hi_d = hw_in;
        else begin
          data_d = {hi_q, hw_in}; evt_d = 1'b1; wd_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 1'b1; stb_q <= 1'b0; hi_q <= '0;
      sync_data <= '0; sync_evt <= 1'b0; sync_wd <= 1'b0;
    end else begin
      sync_q <= sync_n; stb_q <= byte_stb; hi_q <= hi_d;
      sync_data <= data_d; sync_evt <= evt_d; sync_wd <= wd_d;
    end
  end

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (sync_n && !lrst) |=> $stable(sync_data));
  p_clear_r10: assert property (@(posedge clk) disable iff (!arst_n)
    lrst |=> (sync_data == '0 && !sync_evt));
endmodule

// File: rtl/sr_vec_drv.sv
module sr_vec_drv #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned BYTE_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] vec,
  input  logic              vec_en_n,
  input  logic              byte_hi,
  output logic [BYTE_W-1:0] hw_out,
  output logic              hw_oe
);
  always_comb begin
    hw_oe  = ~vec_en_n;
    hw_out = '0;
    if (!vec_en_n) hw_out = byte_hi ? vec[WORD_W-1:BYTE_W] : vec[BYTE_W-1:0];
  end
endmodule

// File: rtl/sr_rst_gen.sv
module sr_rst_gen #(
  parameter int unsigned RST_CYC = 4,
  localparam int unsigned CNT_W = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_cmd_n,
  output logic sub_rst_n,
  output logic lrst
);
  logic             rp_q, fall;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    fall  = ~rst_cmd_n & rp_q;
    cnt_d = cnt_q;
    if (fall) cnt_d = CNT_W'(RST_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rp_q <= 1'b1; cnt_q <= '0;
    end else begin
      rp_q <= rst_cmd_n; cnt_q <= cnt_d;
    end
  end

  assign lrst      = (cnt_q != '0);
  assign sub_rst_n = ~lrst;

  p_rst_start_r9: assert property (@(posedge clk) disable iff (!arst_n)
    fall |=> !sub_rst_n);
endmodule

// File: rtl/stat_mode_resp.sv
module stat_mode_resp
  import sr_pkg::*;
#(
  parameter int unsigned SA_W    = SA_W_DEF,
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned RST_CYC = RST_CYC_DEF,
  localparam int unsigned NSA    = 1 << SA_W,
  localparam int unsigned BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NSA-1:0]    mask_wdata,
  input  logic              vec_we,
  input  logic [WORD_W-1:0] vec_wdata,
  input  logic              cmd_act_n,
  input  logic [SA_W-1:0]   subaddr,
  input  logic              wc4,
  input  logic              sync_n,
  input  logic              vec_en_n,
  input  logic              rst_cmd_n,
  input  logic              byte_stb,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] hw_in,
  output logic              busy,
  output logic [BYTE_W-1:0] hw_out,
  output logic              hw_oe,
  output logic              sync_evt,
  output logic              sync_wd,
  output logic [WORD_W-1:0] sync_data,
  output logic              sub_rst_n
);
  logic [1:0]        rsync_q;
  logic              arst_n, lrst;
  logic [NSA-1:0]    mask_q;
  logic [WORD_W-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  sr_host_regs #(.NSA(NSA), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .arst_n(arst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .mask_q(mask_q), .vec_q(vec_q));

  sr_busy_sel #(.SA_W(SA_W)) u_busy (
    .clk(clk), .arst_n(arst_n), .cmd_act_n(cmd_act_n), .subaddr(subaddr),
    .mask(mask_q), .busy(busy));

  sr_rst_gen #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_cmd_n(rst_cmd_n),
    .sub_rst_n(sub_rst_n), .lrst(lrst));

  sr_sync_cap #(.WORD_W(WORD_W)) u_sync (
    .clk(clk), .arst_n(arst_n), .lrst(lrst), .sync_n(sync_n), .wc4(wc4),
    .byte_stb(byte_stb), .byte_hi(byte_hi), .hw_in(hw_in),
    .sync_evt(sync_evt), .sync_wd(sync_wd), .sync_data(sync_data));

  sr_vec_drv #(.WORD_W(WORD_W)) u_vec (
    .vec(vec_q), .vec_en_n(vec_en_n), .byte_hi(byte_hi),
    .hw_out(hw_out), .hw_oe(hw_oe));

  p_vec_gate_r7: assert property (@(posedge clk) disable iff (!arst_n)
    vec_en_n |-> (hw_out == '0 && !hw_oe));
endmodule

// File: tb/stat_mode_resp_test.sv
module stat_mode_resp_test;
  localparam int PERIOD = 10;
  localparam int RSTC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mask_we = 0, vec_we = 0, cmd_act_n = 1, wc4 = 0, sync_n = 1;
  logic vec_en_n = 1, rst_cmd_n = 1, byte_stb = 0, byte_hi = 0;
  logic [31:0] mask_wdata = '0;
  logic [15:0] vec_wdata = '0;
  logic [4:0]  subaddr = '0;
  logic [7:0]  hw_in = '0;
  logic busy, hw_oe, sync_evt, sync_wd, sub_rst_n;
  logic [7:0] hw_out;
  logic [15:0] sync_data;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit m_cmd_prev = 1, m_sync_prev = 1, m_stb_prev = 0, m_rp_prev = 1;
  bit m_busy = 0, m_evt = 0, m_wd = 0;
  int m_sa = 0, m_rcnt = 0;
  logic [31:0] m_mask = '0;
  logic [15:0] m_vec = '0, m_data = '0;
  logic [7:0]  m_hi = '0;

  always #(PERIOD/2) clk = ~clk;

  stat_mode_resp uut (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .cmd_act_n(cmd_act_n),
    .subaddr(subaddr), .wc4(wc4), .sync_n(sync_n), .vec_en_n(vec_en_n),
    .rst_cmd_n(rst_cmd_n), .byte_stb(byte_stb), .byte_hi(byte_hi),
    .hw_in(hw_in), .busy(busy), .hw_out(hw_out), .hw_oe(hw_oe),
    .sync_evt(sync_evt), .sync_wd(sync_wd), .sync_data(sync_data),
    .sub_rst_n(sub_rst_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit start, lr, rise, sfall, rfall;
    start = !cmd_act_n && m_cmd_prev;
    if (start) m_sa = subaddr;
    m_busy = !cmd_act_n && m_mask[m_sa];
    m_cmd_prev = cmd_act_n;
    lr = (m_rcnt != 0);
    rise = byte_stb && !m_stb_prev;
    sfall = !sync_n && m_sync_prev;
    m_evt = 0;
    if (lr) begin
      m_hi = 0; m_data = 0; m_wd = 0;
    end else begin
      if (sfall && !wc4) begin m_evt = 1; m_wd = 0; end
      if (rise && !sync_n) begin
        if (byte_hi) m_hi = hw_in;
        else begin m_data = {m_hi, hw_in}; m_evt = 1; m_wd = 1; end
      end
    end
    m_stb_prev = byte_stb; m_sync_prev = sync_n;
    rfall = !rst_cmd_n && m_rp_prev;
    m_rp_prev = rst_cmd_n;
    if (rfall) m_rcnt = RSTC; else if (m_rcnt != 0) m_rcnt--;
    if (mask_we) m_mask = mask_wdata;
    if (vec_we) m_vec = vec_wdata;
  endtask

  task automatic compare_all();
    logic [7:0] ev;
    ev = vec_en_n ? 8'h00 : (byte_hi ? m_vec[15:8] : m_vec[7:0]);
    chk("R2/R3 busy", busy, m_busy);
    chk("R4/R5 sync_evt", sync_evt, m_evt);
    chk("R4/R5 sync_wd", sync_wd, m_wd);
    chk("R5/R6/R10 sync_data", sync_data, m_data);
    chk("R9 sub_rst_n", sub_rst_n, m_rcnt == 0);
    chk("R7 hw_oe", hw_oe, !vec_en_n);
    chk("R7/R8/R11 hw_out", hw_out, ev);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_edge();
      @(negedge clk); compare_all();
    end
  endtask

  task automatic strobe(input bit hi, input logic [7:0] b);
    byte_hi = hi; hw_in = b; byte_stb = 1; step();
    byte_stb = 0; step();
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while in reset
    chk("R1 busy", busy, 0); chk("R1 sync_evt", sync_evt, 0);
    chk("R1 sync_data", sync_data, 0); chk("R1 sub_rst_n", sub_rst_n, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    step(2);
    // R11: host writes, mask bits 3 and 31, vector A55A
    mask_we = 1; mask_wdata = 32'h8000_0008; vec_we = 1; vec_wdata = 16'hA55A;
    step();
    mask_we = 0; vec_we = 0; step();
    // R2: masked subaddress 3, subaddress change mid-command ignored
    subaddr = 5'd3; cmd_act_n = 0; step(2);
    subaddr = 5'd4; step(3);
    cmd_act_n = 1; step(2);   // R3 clears
    // R3: unmasked subaddress 4
    subaddr = 5'd4; cmd_act_n = 0; step(4);
    cmd_act_n = 1; step();
    // R4: subaddress 31 mode command, sync without data
    subaddr = 5'd31; cmd_act_n = 0; step();
    wc4 = 0; sync_n = 0; step(3);
    sync_n = 1; cmd_act_n = 1; step(2);
    // R5/R8: sync with data while busy
    subaddr = 5'd3; cmd_act_n = 0; step();
    wc4 = 1; sync_n = 0; step();
    strobe(1, 8'h12); strobe(0, 8'h34);
    sync_n = 1; step();
    // R7/R8: vector drive while busy
    vec_en_n = 0; byte_hi = 1; step(2);
    byte_hi = 0; step(2);
    vec_en_n = 1; cmd_act_n = 1; step();
    // R6: strobes ignored with sync high
    strobe(1, 8'hEE); strobe(0, 8'hDD);
    // R9/R10: local reset clears capture and ignores strobes
    rst_cmd_n = 0; step();
    rst_cmd_n = 1; sync_n = 0; wc4 = 1;
    strobe(1, 8'h77); strobe(0, 8'h66);
    step(2);
    strobe(1, 8'h5C); strobe(0, 8'hC5);
    sync_n = 1; step();
    // R11: rewrite vector and mask, re-run
    vec_we = 1; vec_wdata = 16'h0FF0; mask_we = 1; mask_wdata = 32'h0000_0010;
    step();
    vec_we = 0; mask_we = 0;
    vec_en_n = 0; byte_hi = 1; step(); byte_hi = 0; step(); vec_en_n = 1;
    subaddr = 5'd3; cmd_act_n = 0; step(3); cmd_act_n = 1; step();
    subaddr = 5'd4; cmd_act_n = 0; step(3); cmd_act_n = 1; step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule